// File: doc/BRIEF.md
# Automatic Level Control Gain Loop

This block closes a digital gain loop around a programmable-gain amplifier. Once per sample it receives the peak magnitude of the incoming signal and compares it with a selectable target level. When the peak is too loud, the loop lowers the amplifier gain code one step at a time at the attack rate. When the peak is too quiet, the loop first waits out an optional hold interval and then raises the gain at the decay rate. The gain code always stays inside a programmable floor and ceiling.

A mode input switches the loop into peak-limiter behaviour. In that mode all stepping periods are four times shorter and the hold interval is skipped. When the block is disabled, the output passes a manual gain code straight through, and the loop restarts from that code when it is enabled again. All time constants are counted in samples, so their real-time values scale with the sample rate. One gain code step stands for 0.75 dB, so eight steps make up 6 dB.

Top module: `alc_gain_loop`

## Requirements
- R1: While `alc_en` is low, `gain_code` equals `manual_gain` and strobed samples have no effect. During reset the internal gain is zero, so with `alc_en` high after reset the output shows `min_gain`.
- R2: The target for `target_sel` = c is floor(floor(2^(PEAK_W-1) / 2^(c div 4)) * F / 256), where F is 256, 215, 181 or 153 for c mod 4 = 0, 1, 2 or 3. Code 0 is -6 dB and code 15 is -28.5 dB, in 1.5 dB steps. A peak is above the target only if it is strictly greater.
- R3: Each strobed sample whose peak is above the target counts toward an attack step, with no hold delay. The gain falls by one code on every A-th such sample, where A = ATTACK_BASE << min(attack_sel, RATE_MAX). A below-target sample clears this count.
- R4: Once the hold has expired, the gain rises by one code on every D-th below-target sample, where D = DECAY_BASE << min(decay_sel, RATE_MAX).
- R5: The hold length is zero samples when `hold_sel` = 0, and HOLD_BASE << (hold_sel-1) below-target samples otherwise. No decay step is counted until that many below-target samples have passed.
- R6: An above-target sample restarts both the hold count and the decay count.
- R7: A sample whose peak equals the target changes neither the gain nor any count. The gain never changes on a clock where no sample was strobed, and it never moves by more than one code per sample.
- R8: While enabled, `gain_code` is the internal gain clamped first to `max_gain` and then to `min_gain`. A change to either limit takes effect on the output at once.
- R9: With `limiter_mode` high, the attack and decay periods are shifted right by two, with a minimum of one sample, and the hold length is zero whatever `hold_sel` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alc_en | input | 1 | Loop enable; low selects the manual gain |
| limiter_mode | input | 1 | High selects peak-limiter behaviour |
| sample_stb | input | 1 | One-cycle strobe marking a valid peak sample |
| peak_mag | input | PEAK_W | Unsigned peak magnitude of the current sample |
| target_sel | input | 4 | Target level code (-6 dB down to -28.5 dB) |
| max_gain | input | GAIN_W | Upper gain code limit |
| min_gain | input | GAIN_W | Lower gain code limit |
| hold_sel | input | 4 | Hold interval code, 0 = no hold |
| decay_sel | input | 4 | Gain-increase rate code |
| attack_sel | input | 4 | Gain-decrease rate code |
| manual_gain | input | GAIN_W | Gain code used while the loop is disabled |
| gain_code | output | GAIN_W | Gain code to the amplifier |

## Verification
Above-target sample runs check the attack spacing at two rate codes. Long below-target runs show where the hold ends and the decay begins. An above-target sample in the middle of the hold tells a restarted hold apart from a paused one. Equal-to-target samples placed inside the hold tell "no effect" apart from "reset" and from "advance". In limiter mode, peaks of target+1, target and target-1 at several target codes pin the threshold mapping to the exact value. Long runs into the ceiling and the floor, followed by limit changes, separate the output clamp from the stepping logic.

// File: rtl/alc_pkg.sv
package alc_pkg;

  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    LVL_BELOW = 2'd0,
    LVL_EQUAL = 2'd1,
    LVL_ABOVE = 2'd2
  } lvl_e;

  // Samples per gain step: base doubled per rate code, quartered when fast.
  function automatic logic [31:0] step_period(input logic [31:0] base,
                                              input logic [SEL_W-1:0] sel,
                                              input logic [SEL_W-1:0] sel_max,
                                              input logic fast);
    logic [SEL_W-1:0] s;
    logic [31:0] p;
    s = (sel > sel_max) ? sel_max : sel;
    p = base << s;
    if (fast) p = p >> 2;
    if (p == 32'd0) p = 32'd1;
    return p;
  endfunction

  // Below-target samples to wait before gain may rise.
  function automatic logic [31:0] hold_length(input logic [31:0] base,
                                              input logic [SEL_W-1:0] sel,
                                              input logic fast);
    logic [31:0] h;
    if (fast || sel == '0) h = 32'd0;
    else h = base << (sel - 1'b1);
    return h;
  endfunction

endpackage

// File: rtl/alc_level_cmp.sv
module alc_level_cmp
  import alc_pkg::*;
#(
  parameter int PEAK_W = 16
) (
  input  logic [PEAK_W-1:0] peak_mag,
  input  logic [SEL_W-1:0]  target_sel,
  output lvl_e              level
);

  localparam int PW = PEAK_W + 9;

  logic [PW-1:0]     frac;
  logic [PW-1:0]     scaled;
  logic [PW-1:0]     prod;
  logic [PEAK_W-1:0] target;

  // 1.5 dB sub-steps inside one 6 dB octave, Q8 fractions.
  always_comb begin
    case (target_sel[1:0])
      2'd0:    frac = PW'(256);
      2'd1:    frac = PW'(215);
      2'd2:    frac = PW'(181);
      default: frac = PW'(153);
    endcase
    scaled = (PW'(1) << (PEAK_W - 1)) >> target_sel[SEL_W-1:2];
    prod   = scaled * frac;
    target = PEAK_W'(prod >> 8);
  end

  always_comb begin
    if (peak_mag > target)       level = LVL_ABOVE;
    else if (peak_mag == target) level = LVL_EQUAL;
    else                         level = LVL_BELOW;
  end

endmodule

// File: rtl/alc_step_timer.sv
module alc_step_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign tick   = adv && !clr && (cnt_q >= period - 1'b1);
  assign cnt_en = clr || adv;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (adv)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/alc_hold_timer.sv
module alc_hold_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] len,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q >= len);
  assign cnt_en = clr || (adv && !done);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (adv && !done)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/alc_gain_loop.sv
module alc_gain_loop
  import alc_pkg::*;
#(
  parameter int PEAK_W      = 16,
  parameter int GAIN_W      = 6,
  parameter int CNT_W       = 24,
  parameter int HOLD_BASE   = 128,
  parameter int DECAY_BASE  = 16,
  parameter int ATTACK_BASE = 4,
  parameter int RATE_MAX    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alc_en,
  input  logic              limiter_mode,
  input  logic              sample_stb,
  input  logic [PEAK_W-1:0] peak_mag,
  input  logic [SEL_W-1:0]  target_sel,
  input  logic [GAIN_W-1:0] max_gain,
  input  logic [GAIN_W-1:0] min_gain,
  input  logic [SEL_W-1:0]  hold_sel,
  input  logic [SEL_W-1:0]  decay_sel,
  input  logic [SEL_W-1:0]  attack_sel,
  input  logic [GAIN_W-1:0] manual_gain,
  output logic [GAIN_W-1:0] gain_code
);

  localparam logic [SEL_W-1:0] RATE_LIM = SEL_W'(RATE_MAX);

  lvl_e              level;
  logic              smp_above;
  logic              smp_below;
  logic              loop_off;
  logic [CNT_W-1:0]  atk_period;
  logic [CNT_W-1:0]  dcy_period;
  logic [CNT_W-1:0]  hold_len;
  logic              atk_tick;
  logic              dcy_tick;
  logic              hold_done;
  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] gain_d;
  logic [GAIN_W-1:0] gain_cl;
  logic              gain_en;

  alc_level_cmp #(.PEAK_W(PEAK_W)) u_cmp (
    .peak_mag   (peak_mag),
    .target_sel (target_sel),
    .level      (level)
  );

  assign loop_off  = !alc_en;
  assign smp_above = alc_en && sample_stb && (level == LVL_ABOVE);
  assign smp_below = alc_en && sample_stb && (level == LVL_BELOW);

  assign atk_period = CNT_W'(step_period(32'(ATTACK_BASE), attack_sel, RATE_LIM, limiter_mode));
  assign dcy_period = CNT_W'(step_period(32'(DECAY_BASE),  decay_sel,  RATE_LIM, limiter_mode));
  assign hold_len   = CNT_W'(hold_length(32'(HOLD_BASE), hold_sel, limiter_mode));

  alc_step_timer #(.CNT_W(CNT_W)) u_attack (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (loop_off || smp_below),
    .adv    (smp_above),
    .period (atk_period),
    .tick   (atk_tick)
  );

  alc_hold_timer #(.CNT_W(CNT_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (loop_off || smp_above),
    .adv   (smp_below),
    .len   (hold_len),
    .done  (hold_done)
  );

  alc_step_timer #(.CNT_W(CNT_W)) u_decay (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (loop_off || smp_above),
    .adv    (smp_below && hold_done),
    .period (dcy_period),
    .tick   (dcy_tick)
  );

  // Ceiling first, then floor: the floor wins if limits cross.
  always_comb begin
    gain_cl = (gain_q > max_gain) ? max_gain : gain_q;
    gain_cl = (gain_cl < min_gain) ? min_gain : gain_cl;
  end

  assign gain_en = loop_off || atk_tick || dcy_tick;

  always_comb begin
    gain_d = gain_q;
    if (loop_off) begin
      gain_d = manual_gain;
    end else if (atk_tick) begin
      gain_d = (gain_cl > min_gain) ? gain_cl - 1'b1 : gain_cl;
    end else if (dcy_tick) begin
      gain_d = (gain_cl < max_gain) ? gain_cl + 1'b1 : gain_cl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_q <= '0;
    else if (gain_en) gain_q <= gain_d;
  end

  assign gain_code = alc_en ? gain_cl : manual_gain;

endmodule

// File: rtl/alc_gain_checker.sv
module alc_gain_checker #(
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alc_en,
  input logic              sample_stb,
  input logic [GAIN_W-1:0] max_gain,
  input logic [GAIN_W-1:0] min_gain,
  input logic [GAIN_W-1:0] manual_gain,
  input logic [GAIN_W-1:0] gain_code
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: manual pass-through while disabled
  a_r1_manual_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !alc_en |-> (gain_code == manual_gain));

  // R8: output inside the window whenever the window is well formed
  a_r8_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_en && (max_gain >= min_gain)) |-> ((gain_code <= max_gain) && (gain_code >= min_gain)));

  // R7: no movement on clocks without a sample
  a_r7_quiet_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && alc_en && $past(alc_en) && !$past(sample_stb) &&
     $stable(max_gain) && $stable(min_gain)) |-> $stable(gain_code));

  // R7: at most one code per sample
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && alc_en && $past(alc_en) && $stable(max_gain) && $stable(min_gain)) |->
    (({1'b0, gain_code} <= {1'b0, $past(gain_code)} + 1'b1) &&
     ({1'b0, $past(gain_code)} <= {1'b0, gain_code} + 1'b1)));

endmodule

bind alc_gain_loop alc_gain_checker #(.GAIN_W(GAIN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alc_en      (alc_en),
  .sample_stb  (sample_stb),
  .max_gain    (max_gain),
  .min_gain    (min_gain),
  .manual_gain (manual_gain),
  .gain_code   (gain_code)
);

// File: tb/sim_alc_gain_loop.sv
`timescale 1ns/1ps
module sim_alc_gain_loop;

  localparam int PEAK_W = 16;
  localparam int GAIN_W = 6;

  logic              clk;
  logic              rst_n;
  logic              alc_en;
  logic              limiter_mode;
  logic              sample_stb;
  logic [PEAK_W-1:0] peak_mag;
  logic [3:0]        target_sel;
  logic [GAIN_W-1:0] max_gain;
  logic [GAIN_W-1:0] min_gain;
  logic [3:0]        hold_sel;
  logic [3:0]        decay_sel;
  logic [3:0]        attack_sel;
  logic [GAIN_W-1:0] manual_gain;
  logic [GAIN_W-1:0] gain_code;

  alc_gain_loop u0 (
    .clk(clk), .rst_n(rst_n), .alc_en(alc_en), .limiter_mode(limiter_mode),
    .sample_stb(sample_stb), .peak_mag(peak_mag), .target_sel(target_sel),
    .max_gain(max_gain), .min_gain(min_gain), .hold_sel(hold_sel),
    .decay_sel(decay_sel), .attack_sel(attack_sel), .manual_gain(manual_gain),
    .gain_code(gain_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct { int exp; string req; } item_t;
  item_t sb_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference state built from the requirements.
  int m_gain, m_acnt, m_dcnt, m_hcnt;

  function automatic int clampg(int g);
    int c;
    c = (g > int'(max_gain)) ? int'(max_gain) : g;
    c = (c < int'(min_gain)) ? int'(min_gain) : c;
    return c;
  endfunction

  function automatic int tgt(int sel);
    int f;
    case (sel % 4)
      0: f = 256;
      1: f = 215;
      2: f = 181;
      default: f = 153;
    endcase
    return ((32768 >> (sel / 4)) * f) / 256;
  endfunction

  function automatic int per(int base, int sel, bit fast);
    int s, p;
    s = (sel > 10) ? 10 : sel;
    p = base << s;
    if (fast) p = p >> 2;
    if (p == 0) p = 1;
    return p;
  endfunction

  function automatic int holdlen();
    if (limiter_mode || hold_sel == 0) return 0;
    return 128 << (int'(hold_sel) - 1);
  endfunction

  function automatic int expected_out();
    return alc_en ? clampg(m_gain) : int'(manual_gain);
  endfunction

  task automatic model_sample(int pk);
    int t, a, d, h, c;
    if (!alc_en) begin
      m_gain = manual_gain; m_acnt = 0; m_dcnt = 0; m_hcnt = 0;
      return;
    end
    t = tgt(target_sel);
    a = per(4, attack_sel, limiter_mode);
    d = per(16, decay_sel, limiter_mode);
    h = holdlen();
    c = clampg(m_gain);
    if (pk > t) begin
      m_hcnt = 0; m_dcnt = 0;
      if (m_acnt >= a - 1) begin
        m_acnt = 0;
        m_gain = (c > int'(min_gain)) ? c - 1 : c;
      end else m_acnt++;
    end else if (pk < t) begin
      m_acnt = 0;
      if (m_hcnt < h) m_hcnt++;
      else if (m_dcnt >= d - 1) begin
        m_dcnt = 0;
        m_gain = (c < int'(max_gain)) ? c + 1 : c;
      end else m_dcnt++;
    end
  endtask

  task automatic drive_sample(int pk, string req);
    item_t it;
    model_sample(pk);
    it.exp = expected_out();
    it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    sample_stb = 1'b1;
    peak_mag   = PEAK_W'(pk);
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  task automatic drive_run(int pk, int n, string req);
    for (int i = 0; i < n; i++) drive_sample(pk, req);
  endtask

  task automatic check_now(int exp, string req);
    n_checks++;
    if (int'(gain_code) != exp) begin
      n_fail++;
      $display("FAIL %s: gain_code=%0d expected=%0d", req, gain_code, exp);
    end
  endtask

  // Monitor: pops one expected item per strobed sample.
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      if (sample_stb === 1'b1) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL scoreboard: gain_code=%0d expected=<none>", gain_code);
        end else begin
          it = sb_q.pop_front();
          check_now(it.exp, it.req);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: gain_code=%0d expected=<done>", gain_code);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; alc_en = 1'b1; limiter_mode = 1'b0; sample_stb = 1'b0;
    peak_mag = '0; target_sel = 4'd0; max_gain = 6'd40; min_gain = 6'd8;
    hold_sel = 4'd1; decay_sel = 4'd0; attack_sel = 4'd0; manual_gain = 6'd20;
    m_gain = 0; m_acnt = 0; m_dcnt = 0; m_hcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_now(8, "R1 reset shows floor");
    check_now(expected_out(), "R8 reset clamp");

    // R1: disabled pass-through, samples ignored
    alc_en = 1'b0;
    m_gain = 20; m_acnt = 0; m_dcnt = 0; m_hcnt = 0;
    #1 check_now(20, "R1 manual pass");
    drive_run(40000, 6, "R1 samples ignored");
    @(negedge clk);
    alc_en = 1'b1;
    @(negedge clk);
    check_now(20, "R1 restart from manual");

    // R3: attack every 4 above-target samples
    drive_run(40000, 12, "R3 attack A=4");
    // R7: equal target has no effect
    drive_run(32768, 5, "R7 equal no change");
    // R5/R7: equal samples inside the hold do not advance it
    drive_run(100, 100, "R5 hold wait");
    drive_run(32768, 40, "R7 equal in hold");
    drive_run(100, 44, "R5 hold expiry");
    drive_run(100, 16, "R4 decay D=16");
    // R6: one loud sample restarts the hold
    drive_sample(40000, "R6 restart");
    drive_run(100, 144, "R6 hold rerun");
    // R3 at a slower rate
    attack_sel = 4'd2;
    drive_run(40000, 17, "R3 attack A=16");

    // R2/R9: limiter mode, threshold edges at several codes
    limiter_mode = 1'b1; attack_sel = 4'd0; hold_sel = 4'd5;
    for (int k = 0; k < 4; k++) begin
      target_sel = 4'(5 * k);
      drive_sample(tgt(5 * k) + 1, "R2 above edge");
      drive_sample(tgt(5 * k), "R2 equal edge");
      drive_sample(tgt(5 * k) - 1, "R2 below edge");
    end
    target_sel = 4'd0;
    drive_run(100, 8, "R9 fast decay no hold");
    attack_sel = 4'd2;
    drive_run(40000, 4, "R9 fast attack");

    // R8: drive into the ceiling, then move limits
    attack_sel = 4'd0;
    drive_run(100, 160, "R8 ceiling");
    check_now(40, "R8 at ceiling");
    @(negedge clk);
    max_gain = 6'd30;
    #1 check_now(30, "R8 ceiling lowered");
    drive_run(40000, 40, "R8 floor");
    check_now(8, "R8 at floor");
    @(negedge clk);
    min_gain = 6'd12;
    #1 check_now(12, "R8 floor raised");
    drive_run(100, 6, "R8 rise from raised floor");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: gain_code=%0d expected=<%0d pending>", gain_code, sb_q.size());
    end
    finish_run();
  end

endmodule